// File: doc/BRIEF.md
# Bidirectional Bus Port

This block is an 8-bit data port with two ways of working. In static mode it keeps an output register. The core can load that register, clear bits in it with an AND mask, or set bits in it with an OR mask. When the static drive bit is set, the register value is driven onto the pins. One output enable serves all eight lines, so the port is always wholly an input or wholly an output.

In transfer mode, the core issues an external read or an external write. The port answers with a single active-low strobe cycle. During a write strobe it drives the write data. During a read strobe it releases the pins and captures the pin value at the edge that ends the strobe. Outside a strobe, and with the static drive bit clear, the bus is high impedance. The core also has a plain sample operation that reads the pins without any strobe.

The core sends one operation per cycle with `op_valid`. An operation counts only while `op_ready` is high. `op_ready` is low only during a strobe cycle.

Top module: `xbus_port`

## Requirements
- R1: After synchronous reset: `bus_oe`=0, `rd_n`=1, `wr_n`=1, `op_ready`=1, `rd_valid`=0. The output register holds `RESET_VAL` (default 8'h00) and the static drive bit is 0.
- R2: Operation code 1 (load) puts `op_data` into the output register. While the static drive bit is 1 and no strobe is active, `bus_out` equals the register and `bus_oe`=1 from the cycle after acceptance.
- R3: Operation code 2 (AND mask) replaces the register with register AND `op_data`.
- R4: Operation code 3 (OR mask) replaces the register with register OR `op_data`.
- R5: Operation code 7 sets the static drive bit to `op_data[0]`. Outside strobes, `bus_oe` equals that bit. The single `bus_oe` governs all eight lines.
- R6: Operation code 6 (external write) drives `wr_n`=0, `bus_oe`=1 and `bus_out`=`op_data` for exactly the one cycle after acceptance. The output register is left unchanged.
- R7: Operation code 5 (external read) drives `rd_n`=0 and `bus_oe`=0 for exactly the one cycle after acceptance. `bus_in` is captured at the edge that ends that cycle, and `rd_data` shows it with `rd_valid`=1 in the following cycle.
- R8: `rd_n` and `wr_n` are never low together, and neither stays low for two cycles in a row.
- R9: `op_ready` is 0 during any strobe cycle. An operation presented then is ignored: it changes neither the register, the static bit, nor the strobes.
- R10: Operation code 4 (sample) captures `bus_in` at the acceptance edge. `rd_data` shows it with `rd_valid`=1 in the next cycle, and no strobe is produced. Code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation request from the core |
| op_code | input | 3 | Operation code (0 none, 1 load, 2 AND, 3 OR, 4 sample, 5 ext read, 6 ext write, 7 static bit) |
| op_data | input | 8 | Operand: load value, mask, write data or mode bit |
| op_ready | output | 1 | High when an operation can be accepted |
| bus_in | input | 8 | Pin values seen from outside |
| bus_out | output | 8 | Value to drive on the pins |
| bus_oe | output | 1 | Output enable shared by all eight lines |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| rd_data | output | 8 | Last sampled or read pin value |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is updated |

## Verification
The assertions assume that `op_code` and `op_data` are at known values whenever `op_valid` is high. They also assume that `bus_in` is known at every edge that ends a read strobe or accepts a sample. The bench drives every input at the falling edge from tasks that always give full values. It lowers `op_valid` after each accepted operation. It presents a request during a strobe only in the directed case that tests the ignore rule. Random codes and operands come from a fixed seed.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int unsigned XB_W = 8;

    typedef enum logic [2:0] {
        XOP_NONE   = 3'd0,
        XOP_LOAD   = 3'd1,
        XOP_AND    = 3'd2,
        XOP_OR     = 3'd3,
        XOP_SAMPLE = 3'd4,
        XOP_XRD    = 3'd5,
        XOP_XWR    = 3'd6,
        XOP_MODE   = 3'd7
    } xbus_op_e;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RSTB = 2'd1,
        XS_WSTB = 2'd2
    } xbus_state_e;

    typedef struct packed {
        logic             valid;
        xbus_op_e         code;
        logic [XB_W-1:0]  data;
    } xbus_req_t;

    // next value of the output register for a register-touching operation
    function automatic logic [XB_W-1:0] xbus_apply(input xbus_op_e op,
                                                   input logic [XB_W-1:0] cur,
                                                   input logic [XB_W-1:0] arg);
        logic [XB_W-1:0] r;
        case (op)
            XOP_LOAD: r = arg;
            XOP_AND:  r = cur & arg;
            XOP_OR:   r = cur | arg;
            default:  r = cur;
        endcase
        return r;
    endfunction

    function automatic logic xbus_touches_latch(input xbus_op_e op);
        return (op == XOP_LOAD) || (op == XOP_AND) || (op == XOP_OR);
    endfunction

endpackage

// File: rtl/xbus_latch.sv
module xbus_latch
    import xbus_pkg::*;
#(
    parameter int unsigned          WIDTH     = 8,
    parameter logic [WIDTH-1:0]     RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  xbus_op_e          code,
    input  logic [WIDTH-1:0]  data,
    output logic [WIDTH-1:0]  latch_q,
    output logic              smode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= RESET_VAL;
            smode_q <= 1'b0;
        end else if (accept) begin
            if (xbus_touches_latch(code)) begin
                latch_q <= xbus_apply(code, latch_q, data);
            end
            if (code == XOP_MODE) begin
                smode_q <= data[0];
            end
        end
    end

endmodule

// File: rtl/xbus_xfer.sv
module xbus_xfer
    import xbus_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  xbus_op_e          code,
    input  logic [WIDTH-1:0]  data,
    input  logic [WIDTH-1:0]  pins,
    output logic              ready,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  cap_data,
    output logic              cap_valid
);

    xbus_state_e state_q, state_d;

    always_comb begin
        state_d = XS_IDLE;
        if (state_q == XS_IDLE && accept) begin
            case (code)
                XOP_XRD: state_d = XS_RSTB;
                XOP_XWR: state_d = XS_WSTB;
                default: state_d = XS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
            wr_data <= '0;
        end else begin
            state_q <= state_d;
            if (accept && code == XOP_XWR) begin
                wr_data <= data;
            end
        end
    end

    // capture at the edge ending a read strobe, or at a sample acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_data  <= '0;
            cap_valid <= 1'b0;
        end else if (state_q == XS_RSTB || (accept && code == XOP_SAMPLE)) begin
            cap_data  <= pins;
            cap_valid <= 1'b1;
        end else begin
            cap_valid <= 1'b0;
        end
    end

    assign ready  = (state_q == XS_IDLE);
    assign rd_stb = (state_q == XS_RSTB);
    assign wr_stb = (state_q == XS_WSTB);

endmodule

// File: rtl/xbus_drive.sv
module xbus_drive #(
    parameter int unsigned WIDTH = 8
) (
    input  logic              smode,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [WIDTH-1:0]  latch_val,
    input  logic [WIDTH-1:0]  wr_val,
    output logic [WIDTH-1:0]  pin_out,
    output logic              pin_oe,
    output logic              rd_n,
    output logic              wr_n
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign pin_out[b] = wr_stb ? wr_val[b] : latch_val[b];
    end

    assign pin_oe = wr_stb | (smode & ~rd_stb);
    assign rd_n   = ~rd_stb;
    assign wr_n   = ~wr_stb;

endmodule

// File: rtl/xbus_port.sv
module xbus_port
    import xbus_pkg::*;
#(
    parameter int unsigned       WIDTH     = XB_W,
    parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [WIDTH-1:0]  op_data,
    output logic              op_ready,
    input  logic [WIDTH-1:0]  bus_in,
    output logic [WIDTH-1:0]  bus_out,
    output logic              bus_oe,
    output logic              rd_n,
    output logic              wr_n,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_valid
);

    xbus_op_e          code;
    logic              accept;
    logic [WIDTH-1:0]  latch_q;
    logic              smode_q;
    logic              rd_stb, wr_stb;
    logic [WIDTH-1:0]  wr_data;

    assign code   = xbus_op_e'(op_code);
    assign accept = op_valid & op_ready;

    xbus_latch #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .code    (code),
        .data    (op_data),
        .latch_q (latch_q),
        .smode_q (smode_q)
    );

    xbus_xfer #(.WIDTH(WIDTH)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .code      (code),
        .data      (op_data),
        .pins      (bus_in),
        .ready     (op_ready),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .cap_data  (rd_data),
        .cap_valid (rd_valid)
    );

    xbus_drive #(.WIDTH(WIDTH)) u_drive (
        .smode     (smode_q),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .latch_val (latch_q),
        .wr_val    (wr_data),
        .pin_out   (bus_out),
        .pin_oe    (bus_oe),
        .rd_n      (rd_n),
        .wr_n      (wr_n)
    );

endmodule

// File: rtl/xbus_port_chk.sv
module xbus_port_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic [WIDTH-1:0]  op_data,
    input logic              op_ready,
    input logic [WIDTH-1:0]  bus_in,
    input logic [WIDTH-1:0]  bus_out,
    input logic              bus_oe,
    input logic              rd_n,
    input logic              wr_n,
    input logic [WIDTH-1:0]  rd_data,
    input logic              rd_valid
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (rd_n && wr_n && !bus_oe && op_ready && !rd_valid));

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R8
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> wr_n);

    // R8
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |=> rd_n);

    // R6
    wr_start_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_code == 3'd6)
        |=> (!wr_n && bus_oe && bus_out == $past(op_data)));

    // R7
    rd_release_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !bus_oe);

    // R7
    rd_start_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_code == 3'd5) |=> !rd_n);

    // R7
    rd_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |=> (rd_valid && rd_data == $past(bus_in)));

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !op_ready);

    // R10
    sample_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_code == 3'd4)
        |=> (rd_valid && rd_data == $past(bus_in) && rd_n && wr_n));

endmodule

bind xbus_port xbus_port_chk #(.WIDTH(WIDTH)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_data  (op_data),
    .op_ready (op_ready),
    .bus_in   (bus_in),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/test_xbus_port.sv
module test_xbus_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [7:0] op_data = 8'h00;
    logic [7:0] bus_in = 8'h00;
    logic       op_ready, bus_oe, rd_n, wr_n, rd_valid;
    logic [7:0] bus_out, rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] m_latch = 8'h00;
    logic       m_smode = 1'b0;

    always #10 clk = ~clk;

    xbus_port i_xbus_port (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_data(op_data), .op_ready(op_ready), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .rd_n(rd_n), .wr_n(wr_n),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_next(input logic [2:0] c, input logic [7:0] cur,
                                              input logic [7:0] d);
        case (c)
            3'd1: return d;
            3'd2: return cur & d;
            3'd3: return cur | d;
            default: return cur;
        endcase
    endfunction

    // idle-state view of the port: direction and static value
    task automatic chk_idle();
        chk("R5 oe follows static bit", {7'd0, bus_oe}, {7'd0, m_smode});
        if (m_smode) chk("R2 static value", bus_out, m_latch);
        chk("R8 rd_n idle", {7'd0, rd_n}, 8'd1);
        chk("R8 wr_n idle", {7'd0, wr_n}, 8'd1);
    endtask

    // called at a falling edge; returns at a falling edge
    task automatic run_op(input logic [2:0] c, input logic [7:0] d, input logic [7:0] pin);
        logic [7:0] nb;
        op_valid = 1'b1; op_code = c; op_data = d; bus_in = pin;
        @(posedge clk); @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0;
        m_latch = model_next(c, m_latch, d);
        if (c == 3'd7) m_smode = d[0];
        case (c)
            3'd4: begin
                chk("R10 sample valid", {7'd0, rd_valid}, 8'd1);
                chk("R10 sample data", rd_data, pin);
            end
            3'd5: begin
                chk("R7 rd_n low", {7'd0, rd_n}, 8'd0);
                chk("R7 bus released", {7'd0, bus_oe}, 8'd0);
                chk("R9 ready low in read", {7'd0, op_ready}, 8'd0);
                nb = 8'($urandom);
                bus_in = nb;
                @(posedge clk); @(negedge clk);
                chk("R7 read valid", {7'd0, rd_valid}, 8'd1);
                chk("R7 read data", rd_data, nb);
            end
            3'd6: begin
                chk("R6 wr_n low", {7'd0, wr_n}, 8'd0);
                chk("R6 oe in write", {7'd0, bus_oe}, 8'd1);
                chk("R6 write data", bus_out, d);
                chk("R8 rd_n high in write", {7'd0, rd_n}, 8'd1);
                @(posedge clk); @(negedge clk);
                chk("R8 wr_n single cycle", {7'd0, wr_n}, 8'd1);
            end
            default: ;
        endcase
        chk_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 oe", {7'd0, bus_oe}, 8'd0);
        chk("R1 rd_n", {7'd0, rd_n}, 8'd1);
        chk("R1 wr_n", {7'd0, wr_n}, 8'd1);
        chk("R1 ready", {7'd0, op_ready}, 8'd1);
        chk("R1 rd_valid", {7'd0, rd_valid}, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        run_op(3'd7, 8'h01, 8'h00);
        chk("R1 reset latch value", bus_out, 8'h00);

        // R2 R3 R4 directed masks
        run_op(3'd1, 8'hFF, 8'h00);
        run_op(3'd2, 8'h0F, 8'h00);
        chk("R3 and result", bus_out, 8'h0F);
        run_op(3'd3, 8'hA0, 8'h00);
        chk("R4 or result", bus_out, 8'hAF);

        // R6 write leaves latch intact
        run_op(3'd6, 8'h3C, 8'h00);
        chk("R6 latch unchanged", bus_out, 8'hAF);

        // R7 read in static mode
        run_op(3'd5, 8'h00, 8'h11);

        // R9 operation offered during a write strobe is ignored
        op_valid = 1'b1; op_code = 3'd6; op_data = 8'h77;
        @(posedge clk); @(negedge clk);
        op_code = 3'd1; op_data = 8'h5A;
        chk("R9 ready low", {7'd0, op_ready}, 8'd0);
        @(posedge clk); @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0;
        chk("R9 no second strobe", {7'd0, wr_n}, 8'd1);
        chk("R9 latch kept", bus_out, 8'hAF);

        // R5 static bit off: bus tristated
        run_op(3'd7, 8'hFE, 8'h00);
        chk("R5 tristate", {7'd0, bus_oe}, 8'd0);
        run_op(3'd0, 8'h12, 8'h00);
        chk("R10 none has no pulse", {7'd0, rd_valid}, 8'd0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            run_op(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule